// File: doc/BRIEF.md
# Balancing Fault Prioritizer and Switch Pattern Guard

This block sits beside the cell-balancing sequencer of a battery-stack gate driver. It watches the handshake with the external DC/DC converter, the bias-good flag, serial-protocol error strobes and the requested switch vectors. Any fault it sees is latched as a 4-bit code that the serial port shifts out on the next readback. Some faults also raise an interrupt toward the host. Each interrupt-raising event sends a single-cycle abort pulse to the sequencer, which treats it like an open-all command.

A second path checks the raw cell-switch and polarity-switch vectors before they reach the gate drivers. If a pattern could short a cell or a rail, all twelve outputs are forced low at once. They stay low until the next serial transaction begins, even if the raw pattern recovers.

The converter-side inputs (done, direction return, bias good, external fault bits) pass through a reset-clearing synchronizer first. All edge detection then runs in the core clock domain.

Top module: `bal_fault_guard`

## Requirements
- R1: After reset the fault code is 0000 and the interrupt and abort outputs are low.
- R2: A rising done edge while enable is high latches {0, ext bits} when the synchronized external fault bits are non-zero, or 1100 when they are zero. In both cases the interrupt is raised.
- R3: A padding-bit error strobe latches 1101 and a ninth-clock error strobe latches 1111. Each raises the interrupt on the next clock edge.
- R4: Direction return equal to direction latches 1110 with the interrupt once the grace window after a direction change has expired. The check is suppressed while a serial transaction is busy.
- R5: After a chip-select falling edge the external fault bits are treated as zero until the direction-set strobe arrives. During that window a done edge reports 1100.
- R6: At a chip-select falling edge, three conditions latch a code without raising the interrupt. Waiting for done latches 1000. Waiting on slew latches 1001. Bias-good low while the command is not open-all latches 1011.
- R7: A falling edge of synchronized bias-good while the command is not open-all latches 1010 and raises the interrupt.
- R8: Priority from highest: external code, 1100, 1101, 1110, 1111, 1010, 1011, 1001, 1000. A new fault replaces the latched code only if it ranks strictly higher.
- R9: The read-clear strobe clears the latched code to 0000 and drops the interrupt, unless a new fault arrives in the same cycle.
- R10: The abort output is a one-cycle pulse in the same cycle the interrupt is set by an event.
- R11: All cell (bit i = cell switch i) and polarity outputs are forced to zero combinationally in three cases: more than two cell bits are set, exactly two non-adjacent cell bits are set, or (pol[3]|pol[0]) & (pol[2]|pol[1]) holds.
- R12: Once forced off, the outputs stay zero until a chip-select falling edge with a legal raw pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_i | input | 1 | Direction currently driven to the converter |
| dir_ret_i | input | 1 | Direction return from the converter (expected inverted) |
| en_i | input | 1 | Enable currently driven to the converter |
| done_i | input | 1 | End-of-cycle indication from the converter |
| ext_fault_i | input | 3 | Fault code bits from the converter |
| bias_good_i | input | 1 | Bias and charge-pump good flag |
| wait_done_i | input | 1 | Sequencer is waiting for a done edge |
| wait_slew_i | input | 1 | Sequencer is waiting for gate slew |
| cs_fall_i | input | 1 | One-cycle strobe at chip-select falling edge |
| xact_busy_i | input | 1 | Serial transaction in progress |
| dir_set_i | input | 1 | Strobe: direction set in the new sequence |
| pad_err_i | input | 1 | Strobe: a padding bit was 1 |
| overclk_err_i | input | 1 | Strobe: a ninth serial clock edge occurred |
| open_all_i | input | 1 | Current command is open-all |
| rd_clear_i | input | 1 | Strobe: fault code read, clear it |
| raw_cell_i | input | 8 | Requested cell switch vector |
| raw_pol_i | input | 4 | Requested polarity switch vector |
| fault_code_o | output | 4 | Latched prioritized fault code |
| fault_irq_o | output | 1 | Fault interrupt |
| fault_abort_o | output | 1 | One-cycle abort request to the sequencer |
| cell_sw_o | output | 8 | Guarded cell switch vector |
| pol_sw_o | output | 4 | Guarded polarity switch vector |

## Verification
The hardest case to reach is the external-fault mask window. It needs a chip-select falling edge first, then a synchronized done edge with non-zero fault bits, and only after that the direction-set strobe. The bench drives that exact order. It then compares the 1100 seen inside the window with the pass-through code seen after the strobe.

The silent 1011 code is also awkward. Bias-good must drop while the command is open-all, so that no interrupting 1010 is logged first. Only then is the command switched away from open-all and chip select dropped.

// File: rtl/bal_fault_pkg.sv
package bal_fault_pkg;
  localparam int CODE_W = 4;
  typedef logic [CODE_W-1:0] fcode_t;

  localparam fcode_t FC_NONE      = 4'h0;
  localparam fcode_t FC_NO_DONE   = 4'h8;
  localparam fcode_t FC_SLEW      = 4'h9;
  localparam fcode_t FC_BIAS_DROP = 4'hA;
  localparam fcode_t FC_BIAS_LOW  = 4'hB;
  localparam fcode_t FC_DONE_BARE = 4'hC;
  localparam fcode_t FC_PAD       = 4'hD;
  localparam fcode_t FC_DIR       = 4'hE;
  localparam fcode_t FC_OVERCLK   = 4'hF;

  // Larger value wins; external pass-through codes 1..7 rank highest.
  function automatic logic [3:0] fault_rank(input fcode_t c);
    logic [3:0] r;
    case (c)
      FC_NONE:      r = 4'd0;
      FC_NO_DONE:   r = 4'd1;
      FC_SLEW:      r = 4'd2;
      FC_BIAS_LOW:  r = 4'd3;
      FC_BIAS_DROP: r = 4'd4;
      FC_OVERCLK:   r = 4'd5;
      FC_DIR:       r = 4'd6;
      FC_PAD:       r = 4'd7;
      FC_DONE_BARE: r = 4'd8;
      default:      r = 4'd9;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/bal_sync.sv
module bal_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/bal_fault_latch.sv
module bal_fault_latch
  import bal_fault_pkg::*;
#(
  parameter int DIR_GRACE = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       done_s,
  input  logic       dir_ret_s,
  input  logic       bias_s,
  input  logic [2:0] ext_s,
  input  logic       dir_i,
  input  logic       en_i,
  input  logic       wait_done_i,
  input  logic       wait_slew_i,
  input  logic       cs_fall_i,
  input  logic       xact_busy_i,
  input  logic       dir_set_i,
  input  logic       pad_err_i,
  input  logic       overclk_err_i,
  input  logic       open_all_i,
  input  logic       rd_clear_i,
  output fcode_t     code_o,
  output logic       irq_o,
  output logic       abort_o,
  output logic       irq_evt_o
);
  localparam int GW = $clog2(DIR_GRACE + 1);
  localparam logic [GW-1:0] GRACE_LOAD = GW'(DIR_GRACE);

  logic          done_d, bias_d, mis_d, dir_d, mask_q, irq_q, abort_q;
  logic [GW-1:0] grace_q;
  fcode_t        code_q;

  logic          done_d_n, bias_d_n, mis_d_n, dir_d_n, mask_n, irq_n, abort_n;
  logic [GW-1:0] grace_n;
  fcode_t        code_n, evt_code, base_code;
  logic          done_rise, bias_fall, mis_now, mis_rise, evt_any, irq_evt;
  logic          bias_low_cs;
  logic [2:0]    ext_eff;

  always_comb begin
    ext_eff     = mask_q ? 3'b000 : ext_s;
    done_rise   = done_s & ~done_d & en_i;
    bias_fall   = bias_d & ~bias_s & ~open_all_i;
    bias_low_cs = cs_fall_i & ~bias_s & ~open_all_i;
    mis_now     = (dir_ret_s == dir_i) & ~xact_busy_i & (grace_q == '0) & (dir_d == dir_i);
    mis_rise    = mis_now & ~mis_d;

    irq_evt = done_rise | pad_err_i | mis_rise | overclk_err_i | bias_fall;

    evt_any  = 1'b1;
    evt_code = FC_NONE;
    if (done_rise)                    evt_code = (ext_eff != 3'b000) ? {1'b0, ext_eff} : FC_DONE_BARE;
    else if (pad_err_i)               evt_code = FC_PAD;
    else if (mis_rise)                evt_code = FC_DIR;
    else if (overclk_err_i)           evt_code = FC_OVERCLK;
    else if (bias_fall)               evt_code = FC_BIAS_DROP;
    else if (bias_low_cs)             evt_code = FC_BIAS_LOW;
    else if (cs_fall_i & wait_slew_i) evt_code = FC_SLEW;
    else if (cs_fall_i & wait_done_i) evt_code = FC_NO_DONE;
    else                              evt_any  = 1'b0;

    base_code = rd_clear_i ? FC_NONE : code_q;
    if (evt_any && (fault_rank(evt_code) > fault_rank(base_code))) code_n = evt_code;
    else                                                           code_n = base_code;

    irq_n   = irq_evt | (irq_q & ~rd_clear_i);
    abort_n = irq_evt;

    if (cs_fall_i)      mask_n = 1'b1;
    else if (dir_set_i) mask_n = 1'b0;
    else                mask_n = mask_q;

    dir_d_n = dir_i;
    if (dir_i != dir_d)      grace_n = GRACE_LOAD;
    else if (grace_q != '0)  grace_n = grace_q - 1'b1;
    else                     grace_n = grace_q;

    done_d_n = done_s;
    bias_d_n = bias_s;
    mis_d_n  = mis_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_d  <= 1'b0;
      bias_d  <= 1'b0;
      mis_d   <= 1'b0;
      dir_d   <= 1'b0;
      mask_q  <= 1'b0;
      irq_q   <= 1'b0;
      abort_q <= 1'b0;
      grace_q <= GRACE_LOAD;
      code_q  <= FC_NONE;
    end else begin
      done_d  <= done_d_n;
      bias_d  <= bias_d_n;
      mis_d   <= mis_d_n;
      dir_d   <= dir_d_n;
      mask_q  <= mask_n;
      irq_q   <= irq_n;
      abort_q <= abort_n;
      grace_q <= grace_n;
      code_q  <= code_n;
    end
  end

  assign code_o    = code_q;
  assign irq_o     = irq_q;
  assign abort_o   = abort_q;
  assign irq_evt_o = irq_evt;
endmodule

// File: rtl/bal_switch_guard.sv
module bal_switch_guard #(
  parameter int N_CELL = 8,
  parameter int N_POL  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_fall_i,
  input  logic [N_CELL-1:0] raw_cell_i,
  input  logic [N_POL-1:0]  raw_pol_i,
  output logic [N_CELL-1:0] cell_o,
  output logic [N_POL-1:0]  pol_o
);
  localparam int CW = $clog2(N_CELL + 1);

  logic [N_CELL-2:0] adj;
  logic [CW-1:0]     cell_cnt;
  logic              pol_clash, bad, trip_q, trip_n;

  for (genvar i = 0; i < N_CELL - 1; i++) begin : g_adj
    assign adj[i] = raw_cell_i[i] & raw_cell_i[i+1];
  end

  always_comb begin
    cell_cnt = '0;
    for (int i = 0; i < N_CELL; i++) cell_cnt = cell_cnt + CW'(raw_cell_i[i]);
  end

  // Outer polarity pair against inner pair.
  assign pol_clash = (raw_pol_i[N_POL-1] | raw_pol_i[0]) & (|raw_pol_i[N_POL-2:1]);

  assign bad = (cell_cnt > CW'(2)) | ((cell_cnt == CW'(2)) & ~(|adj)) | pol_clash;

  always_comb begin
    if (bad)            trip_n = 1'b1;
    else if (cs_fall_i) trip_n = 1'b0;
    else                trip_n = trip_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trip_q <= 1'b0;
    else        trip_q <= trip_n;
  end

  assign cell_o = (bad | trip_q) ? '0 : raw_cell_i;
  assign pol_o  = (bad | trip_q) ? '0 : raw_pol_i;
endmodule

// File: rtl/bal_fault_guard.sv
module bal_fault_guard
  import bal_fault_pkg::*;
#(
  parameter int N_CELL      = 8,
  parameter int N_POL       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int DIR_GRACE   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir_i,
  input  logic              dir_ret_i,
  input  logic              en_i,
  input  logic              done_i,
  input  logic [2:0]        ext_fault_i,
  input  logic              bias_good_i,
  input  logic              wait_done_i,
  input  logic              wait_slew_i,
  input  logic              cs_fall_i,
  input  logic              xact_busy_i,
  input  logic              dir_set_i,
  input  logic              pad_err_i,
  input  logic              overclk_err_i,
  input  logic              open_all_i,
  input  logic              rd_clear_i,
  input  logic [N_CELL-1:0] raw_cell_i,
  input  logic [N_POL-1:0]  raw_pol_i,
  output logic [3:0]        fault_code_o,
  output logic              fault_irq_o,
  output logic              fault_abort_o,
  output logic [N_CELL-1:0] cell_sw_o,
  output logic [N_POL-1:0]  pol_sw_o
);
  localparam int SW = 6;

  logic          rst_meta, core_rst_n;
  logic [SW-1:0] async_bus, sync_bus;
  logic          irq_evt;
  fcode_t        code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      core_rst_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      core_rst_n <= rst_meta;
    end
  end

  assign async_bus = {done_i, dir_ret_i, bias_good_i, ext_fault_i};

  bal_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) sync_i (
    .clk   (clk),
    .rst_n (core_rst_n),
    .d_i   (async_bus),
    .q_o   (sync_bus)
  );

  bal_fault_latch #(.DIR_GRACE(DIR_GRACE)) latch_i (
    .clk           (clk),
    .rst_n         (core_rst_n),
    .done_s        (sync_bus[5]),
    .dir_ret_s     (sync_bus[4]),
    .bias_s        (sync_bus[3]),
    .ext_s         (sync_bus[2:0]),
    .dir_i         (dir_i),
    .en_i          (en_i),
    .wait_done_i   (wait_done_i),
    .wait_slew_i   (wait_slew_i),
    .cs_fall_i     (cs_fall_i),
    .xact_busy_i   (xact_busy_i),
    .dir_set_i     (dir_set_i),
    .pad_err_i     (pad_err_i),
    .overclk_err_i (overclk_err_i),
    .open_all_i    (open_all_i),
    .rd_clear_i    (rd_clear_i),
    .code_o        (code),
    .irq_o         (fault_irq_o),
    .abort_o       (fault_abort_o),
    .irq_evt_o     (irq_evt)
  );

  bal_switch_guard #(.N_CELL(N_CELL), .N_POL(N_POL)) guard_i (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .cs_fall_i  (cs_fall_i),
    .raw_cell_i (raw_cell_i),
    .raw_pol_i  (raw_pol_i),
    .cell_o     (cell_sw_o),
    .pol_o      (pol_sw_o)
  );

  assign fault_code_o = code;
endmodule

// File: rtl/bal_fault_guard_chk.sv
module bal_fault_guard_chk
  import bal_fault_pkg::*;
#(
  parameter int N_CELL = 8,
  parameter int N_POL  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pad_err_i,
  input logic              overclk_err_i,
  input logic              rd_clear_i,
  input logic              irq_evt,
  input logic              fault_irq_o,
  input logic              fault_abort_o,
  input logic [3:0]        fault_code_o,
  input logic [N_CELL-1:0] raw_cell_i,
  input logic [N_POL-1:0]  raw_pol_i,
  input logic [N_CELL-1:0] cell_sw_o,
  input logic [N_POL-1:0]  pol_sw_o
);
  // R10
  abort_with_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_abort_o |-> fault_irq_o);

  // R3
  pad_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pad_err_i |=> (fault_irq_o && fault_abort_o));

  // R3
  overclk_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overclk_err_i |=> (fault_irq_o && fault_abort_o));

  // R9
  clear_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clear_i && !irq_evt) |=> !fault_irq_o);

  // R8
  rank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_clear_i |=> (fault_rank(fault_code_o) >= fault_rank($past(fault_code_o))));

  // R11
  crowd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(raw_cell_i) > 2) |-> (cell_sw_o == '0 && pol_sw_o == '0));

  // R12
  all_or_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cell_sw_o != raw_cell_i) || (pol_sw_o != raw_pol_i)) |-> (cell_sw_o == '0 && pol_sw_o == '0));
endmodule

bind bal_fault_guard bal_fault_guard_chk #(.N_CELL(N_CELL), .N_POL(N_POL)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .pad_err_i     (pad_err_i),
  .overclk_err_i (overclk_err_i),
  .rd_clear_i    (rd_clear_i),
  .irq_evt       (irq_evt),
  .fault_irq_o   (fault_irq_o),
  .fault_abort_o (fault_abort_o),
  .fault_code_o  (fault_code_o),
  .raw_cell_i    (raw_cell_i),
  .raw_pol_i     (raw_pol_i),
  .cell_sw_o     (cell_sw_o),
  .pol_sw_o      (pol_sw_o)
);

// File: tb/bal_fault_guard_tb_top.sv
module bal_fault_guard_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic dir_i, dir_ret_i, en_i, done_i, bias_good_i;
  logic [2:0] ext_fault_i;
  logic wait_done_i, wait_slew_i, cs_fall_i, xact_busy_i, dir_set_i;
  logic pad_err_i, overclk_err_i, open_all_i, rd_clear_i;
  logic [7:0] raw_cell_i;
  logic [3:0] raw_pol_i;
  logic [3:0] fault_code_o;
  logic fault_irq_o, fault_abort_o;
  logic [7:0] cell_sw_o;
  logic [3:0] pol_sw_o;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bal_fault_guard dut_i (
    .clk(clk), .rst_n(rst_n), .dir_i(dir_i), .dir_ret_i(dir_ret_i), .en_i(en_i),
    .done_i(done_i), .ext_fault_i(ext_fault_i), .bias_good_i(bias_good_i),
    .wait_done_i(wait_done_i), .wait_slew_i(wait_slew_i), .cs_fall_i(cs_fall_i),
    .xact_busy_i(xact_busy_i), .dir_set_i(dir_set_i), .pad_err_i(pad_err_i),
    .overclk_err_i(overclk_err_i), .open_all_i(open_all_i), .rd_clear_i(rd_clear_i),
    .raw_cell_i(raw_cell_i), .raw_pol_i(raw_pol_i), .fault_code_o(fault_code_o),
    .fault_irq_o(fault_irq_o), .fault_abort_o(fault_abort_o),
    .cell_sw_o(cell_sw_o), .pol_sw_o(pol_sw_o)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_clear();
    rd_clear_i = 1'b1; step(1); rd_clear_i = 1'b0; step(1);
  endtask

  task automatic pulse_cs();
    cs_fall_i = 1'b1; step(1); cs_fall_i = 1'b0; step(1);
  endtask

  task automatic done_edge(input logic [2:0] ext);
    ext_fault_i = ext; en_i = 1'b1; done_i = 1'b1; step(5);
  endtask

  task automatic done_low();
    done_i = 1'b0; ext_fault_i = 3'b000; step(4);
  endtask

  task automatic t_reset();
    chk("R1 code", fault_code_o, 4'h0);
    chk("R1 irq", fault_irq_o, 1'b0);
    chk("R1 abort", fault_abort_o, 1'b0);
  endtask

  task automatic t_done();
    done_edge(3'b101);
    chk("R2 ext code", fault_code_o, 4'h5);
    chk("R2 ext irq", fault_irq_o, 1'b1);
    pulse_clear();
    chk("R9 code cleared", fault_code_o, 4'h0);
    chk("R9 irq cleared", fault_irq_o, 1'b0);
    done_low();
    done_edge(3'b000);
    chk("R2 bare code", fault_code_o, 4'hC);
    chk("R2 bare irq", fault_irq_o, 1'b1);
    pulse_clear();
    done_low();
  endtask

  task automatic t_strobes();
    pad_err_i = 1'b1; step(1); pad_err_i = 1'b0;
    chk("R10 abort high", fault_abort_o, 1'b1);
    chk("R3 pad code", fault_code_o, 4'hD);
    chk("R3 pad irq", fault_irq_o, 1'b1);
    step(1);
    chk("R10 abort one cycle", fault_abort_o, 1'b0);
    pulse_clear();
    overclk_err_i = 1'b1; step(1); overclk_err_i = 1'b0;
    chk("R3 overclk code", fault_code_o, 4'hF);
    chk("R3 overclk irq", fault_irq_o, 1'b1);
    pulse_clear();
  endtask

  task automatic t_dir();
    xact_busy_i = 1'b1; dir_ret_i = dir_i; step(12);
    chk("R4 masked code", fault_code_o, 4'h0);
    chk("R4 masked irq", fault_irq_o, 1'b0);
    xact_busy_i = 1'b0; step(2);
    chk("R4 mismatch code", fault_code_o, 4'hE);
    chk("R4 mismatch irq", fault_irq_o, 1'b1);
    dir_ret_i = ~dir_i; step(4);
    pulse_clear();
  endtask

  task automatic t_mask();
    pulse_cs();
    chk("R5 cs no code", fault_code_o, 4'h0);
    done_edge(3'b011);
    chk("R5 masked ext", fault_code_o, 4'hC);
    pulse_clear();
    done_low();
    dir_set_i = 1'b1; step(1); dir_set_i = 1'b0; step(1);
    done_edge(3'b011);
    chk("R5 unmasked ext", fault_code_o, 4'h3);
    pulse_clear();
    done_low();
    en_i = 1'b0;
  endtask

  task automatic t_silent();
    wait_done_i = 1'b1; pulse_cs(); wait_done_i = 1'b0;
    chk("R6 no-done code", fault_code_o, 4'h8);
    chk("R6 no-done irq", fault_irq_o, 1'b0);
    pulse_clear();
    wait_slew_i = 1'b1; pulse_cs(); wait_slew_i = 1'b0;
    chk("R6 slew code", fault_code_o, 4'h9);
    chk("R6 slew irq", fault_irq_o, 1'b0);
    pulse_clear();
    open_all_i = 1'b1; bias_good_i = 1'b0; step(4);
    chk("R7 open-all drop ignored", fault_irq_o, 1'b0);
    open_all_i = 1'b0; step(1);
    pulse_cs();
    chk("R6 bias low code", fault_code_o, 4'hB);
    chk("R6 bias low irq", fault_irq_o, 1'b0);
    pulse_clear();
    bias_good_i = 1'b1; step(4);
    bias_good_i = 1'b0; step(4);
    chk("R7 bias drop code", fault_code_o, 4'hA);
    chk("R7 bias drop irq", fault_irq_o, 1'b1);
    pulse_clear();
    bias_good_i = 1'b1; open_all_i = 1'b1; step(4);
  endtask

  task automatic t_priority();
    pad_err_i = 1'b1; step(1); pad_err_i = 1'b0; step(1);
    overclk_err_i = 1'b1; step(1); overclk_err_i = 1'b0; step(1);
    chk("R8 lower kept out", fault_code_o, 4'hD);
    done_edge(3'b000);
    chk("R8 higher replaces", fault_code_o, 4'hC);
    pulse_clear();
    done_low();
    en_i = 1'b0;
  endtask

  task automatic t_guard();
    raw_cell_i = 8'b0000_0011; raw_pol_i = 4'b1001; step(1);
    chk("R11 legal cell", cell_sw_o, 8'h03);
    chk("R11 legal pol", pol_sw_o, 4'h9);
    raw_cell_i = 8'b0000_0101; step(1);
    chk("R11 gap pair", {cell_sw_o, pol_sw_o}, 12'h000);
    raw_cell_i = 8'b0000_0111; step(1);
    chk("R11 three cells", {cell_sw_o, pol_sw_o}, 12'h000);
    raw_cell_i = 8'b0000_0011; raw_pol_i = 4'b0011; step(1);
    chk("R11 pol clash", {cell_sw_o, pol_sw_o}, 12'h000);
    raw_cell_i = 8'b0000_0110; raw_pol_i = 4'b0110; step(2);
    chk("R12 held off", {cell_sw_o, pol_sw_o}, 12'h000);
    pulse_cs();
    chk("R12 released", {cell_sw_o, pol_sw_o}, 12'h066);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    dir_i = 1'b1; dir_ret_i = 1'b0; en_i = 1'b0; done_i = 1'b0; bias_good_i = 1'b1;
    ext_fault_i = 3'b000; wait_done_i = 1'b0; wait_slew_i = 1'b0; cs_fall_i = 1'b0;
    xact_busy_i = 1'b0; dir_set_i = 1'b0; pad_err_i = 1'b0; overclk_err_i = 1'b0;
    open_all_i = 1'b1; rd_clear_i = 1'b0; raw_cell_i = 8'h00; raw_pol_i = 4'h0;
    step(3);
    rst_n = 1'b1;
    step(20);
    t_reset();
    t_done();
    t_strobes();
    t_dir();
    t_mask();
    t_silent();
    t_priority();
    t_guard();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule